// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Sampler

This block sits beside a processor core's sequencer and decides, once per instruction, whether an interrupt is taken at the next instruction boundary. The non-maskable request line (rising-edge sensitive) and the maskable request line (level sensitive) are first brought into the clock domain by a synchronizer chain. Edge events are then recorded in sticky transition flags. The sequencer marks the final work cycle of every instruction with a strobe. Only in that cycle are the recorded events sampled. A sample consumes the transition flags and turns them into latched pending flags.

Because the sample is taken in the final work cycle, it sees the interrupt-disable value that holds before that instruction's own update to the flag. An instruction that clears the disable flag therefore admits a waiting maskable request only at the end of the instruction after it. A lock input keeps sampling off, for example during sequences that must not be split. Acknowledge strobes from the interrupt entry sequencer clear the pending flags. The block also produces three further outputs:
- a one-cycle wake pulse for a core parked in a wait-for-interrupt loop;
- a priority-resolved entry selection;
- a combinational indication that a trailing idle cycle of a short implied instruction must instead be issued as a read at the current program counter, without a counter increment.

Top module: `intr_sample_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is 0. Reset also clears all internal transition and pending flags.
- R2: A 0-to-1 change on `nmi_req_i` records one non-maskable event. The first sample after the event sets `nmi_pend_o` and consumes the event. Holding the line high records no further event. A sample is a cycle with `last_cycle_i`=1 and `lock_i`=0.
- R3: A sample succeeds for the maskable line when a rising edge was recorded or the synchronized line is still high. The sample consumes the recorded edge. It sets `irq_pend_o` only if `irq_disable_i` is 0 in that same sample cycle. A change of the disable flag made by the instruction ending in that cycle therefore acts from the next instruction's sample.
- R4: While `lock_i`=1, no sample happens. Transition flags and pending flags are kept unchanged, except for clearing by an acknowledge.
- R5: `intr_pend_o` is the OR of the two pending flags. It is recomputed only in sample cycles and acknowledge cycles, and otherwise holds its value.
- R6: `wake_o` is 1 for exactly the cycle after a successful sample of either line. This includes a maskable sample that is blocked by the disable flag.
- R7: `idle_to_read_o` is combinational. It equals `idle_slot_i` AND the combined pending value that the current cycle will register. In a final cycle that finds an interrupt, the same cycle's idle slot is already converted.
- R8: `ack_nmi_i` clears `nmi_pend_o` and `ack_irq_i` clears `irq_pend_o` on the next edge. A sample that sets a flag in the same cycle wins over the acknowledge.
- R9: `entry_nmi_o` = `nmi_pend_o`. `entry_irq_o` = `irq_pend_o` AND NOT `nmi_pend_o`, so the non-maskable request has priority and at most one entry output is 1.
- R10: With `SYNC_STAGES`=2, a level applied before clock edge k reaches the sampler as follows. The maskable level can be sampled at edge k+2. The non-maskable edge is recorded at edge k+2 and can first be consumed by a sample at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_req_i | input | 1 | Non-maskable request, rising-edge sensitive, asynchronous |
| irq_req_i | input | 1 | Maskable request, level sensitive, asynchronous |
| irq_disable_i | input | 1 | Current interrupt-disable flag of the core |
| lock_i | input | 1 | Suppresses sampling while high |
| last_cycle_i | input | 1 | Marks the final work cycle of an instruction |
| idle_slot_i | input | 1 | Current cycle is the trailing idle cycle of a short implied instruction |
| ack_nmi_i | input | 1 | Entry sequencer has taken the non-maskable interrupt |
| ack_irq_i | input | 1 | Entry sequencer has taken the maskable interrupt |
| nmi_pend_o | output | 1 | Non-maskable interrupt pending |
| irq_pend_o | output | 1 | Maskable interrupt pending |
| intr_pend_o | output | 1 | Combined pending flag |
| wake_o | output | 1 | One-cycle wake pulse for the wait state |
| idle_to_read_o | output | 1 | Issue the idle slot as a read at the current PC, with no PC increment |
| entry_nmi_o | output | 1 | Entry sequencer should use the non-maskable vector |
| entry_irq_o | output | 1 | Entry sequencer should use the maskable vector |

## Verification
The bench builds the block with the default `SYNC_STAGES`=2. This fixes the request-to-sample latency at two edges for the maskable level and three for the non-maskable edge. With that latency fixed, the stimulus table can place final-cycle strobes one edge early and exactly on time. It can also place the disable-flag clear one instruction ahead of the sample that admits the request, and put a lock on top of a recorded edge. Within the same short run, the table covers a held high level that must not retrigger, acknowledge-versus-sample ordering, and both-pending priority.

// File: rtl/intr_sample_pkg.sv
package intr_sample_pkg;

    localparam int REQ_W   = 2;
    localparam int NMI_IDX = 1;
    localparam int IRQ_IDX = 0;

    typedef struct packed {
        logic nmi_trans;
        logic irq_trans;
        logic nmi_pend;
        logic irq_pend;
        logic intr_pend;
        logic wake;
    } samp_state_t;

endpackage

// File: rtl/intr_sample_sync.sv
module intr_sample_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [WIDTH-1:0] stage_d [DEPTH];
    logic [WIDTH-1:0] stage_q [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = async_i;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/intr_sample_edge.sv
module intr_sample_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    // R2: a rise is reported only when the previous level was low
    // R2
    rise_needs_low_prev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/intr_sample_core.sv
module intr_sample_core
    import intr_sample_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nmi_rise_i,
    input  logic irq_rise_i,
    input  logic irq_level_i,
    input  logic irq_disable_i,
    input  logic lock_i,
    input  logic last_cycle_i,
    input  logic idle_slot_i,
    input  logic ack_nmi_i,
    input  logic ack_irq_i,
    output logic nmi_pend_o,
    output logic irq_pend_o,
    output logic intr_pend_o,
    output logic wake_o,
    output logic idle_to_read_o
);
    samp_state_t st_d, st_q;
    logic        sample_en;
    logic        nmi_hit;
    logic        irq_hit;

    always_comb begin
        st_d      = st_q;
        sample_en = last_cycle_i & ~lock_i;
        nmi_hit   = sample_en & st_q.nmi_trans;
        irq_hit   = sample_en & (st_q.irq_trans | irq_level_i);

        // sample consumes recorded edges; a fresh edge in the same cycle survives
        if (nmi_hit)    st_d.nmi_trans = 1'b0;
        if (nmi_rise_i) st_d.nmi_trans = 1'b1;
        if (irq_hit)    st_d.irq_trans = 1'b0;
        if (irq_rise_i) st_d.irq_trans = 1'b1;

        // acknowledge clears, a same-cycle sample wins
        if (ack_nmi_i)                   st_d.nmi_pend = 1'b0;
        if (nmi_hit)                     st_d.nmi_pend = 1'b1;
        if (ack_irq_i)                   st_d.irq_pend = 1'b0;
        if (irq_hit && !irq_disable_i)   st_d.irq_pend = 1'b1;

        if (sample_en || ack_nmi_i || ack_irq_i)
            st_d.intr_pend = st_d.nmi_pend | st_d.irq_pend;

        st_d.wake      = nmi_hit | irq_hit;
        idle_to_read_o = idle_slot_i & st_d.intr_pend;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign nmi_pend_o  = st_q.nmi_pend;
    assign irq_pend_o  = st_q.irq_pend;
    assign intr_pend_o = st_q.intr_pend;
    assign wake_o      = st_q.wake;

    // R4
    lock_holds_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_i && !ack_nmi_i) |=> (nmi_pend_o == $past(nmi_pend_o)));
    // R4
    lock_holds_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_i && !ack_irq_i) |=> (irq_pend_o == $past(irq_pend_o)));
    // R3
    irq_rise_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_pend_o) |-> $past(last_cycle_i && !lock_i && !irq_disable_i));
    // R2
    nmi_rise_sampled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(nmi_pend_o) |-> $past(last_cycle_i && !lock_i));
    // R5
    combined_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(last_cycle_i && !lock_i) && !ack_nmi_i && !ack_irq_i |=> $stable(intr_pend_o));
    // R6
    wake_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $past(last_cycle_i && !lock_i));
    // R8
    ack_clears_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_nmi_i && !last_cycle_i) |=> !nmi_pend_o);
endmodule

// File: rtl/intr_sample_unit.sv
module intr_sample_unit
    import intr_sample_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nmi_req_i,
    input  logic irq_req_i,
    input  logic irq_disable_i,
    input  logic lock_i,
    input  logic last_cycle_i,
    input  logic idle_slot_i,
    input  logic ack_nmi_i,
    input  logic ack_irq_i,
    output logic nmi_pend_o,
    output logic irq_pend_o,
    output logic intr_pend_o,
    output logic wake_o,
    output logic idle_to_read_o,
    output logic entry_nmi_o,
    output logic entry_irq_o
);
    logic [REQ_W-1:0] req_raw;
    logic [REQ_W-1:0] req_sync;
    logic [REQ_W-1:0] req_rise;

    assign req_raw[NMI_IDX] = nmi_req_i;
    assign req_raw[IRQ_IDX] = irq_req_i;

    intr_sample_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (req_raw),
        .sync_o  (req_sync)
    );

    intr_sample_edge #(.WIDTH(REQ_W)) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (req_sync),
        .rise_o  (req_rise)
    );

    intr_sample_core u_core (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .nmi_rise_i     (req_rise[NMI_IDX]),
        .irq_rise_i     (req_rise[IRQ_IDX]),
        .irq_level_i    (req_sync[IRQ_IDX]),
        .irq_disable_i  (irq_disable_i),
        .lock_i         (lock_i),
        .last_cycle_i   (last_cycle_i),
        .idle_slot_i    (idle_slot_i),
        .ack_nmi_i      (ack_nmi_i),
        .ack_irq_i      (ack_irq_i),
        .nmi_pend_o     (nmi_pend_o),
        .irq_pend_o     (irq_pend_o),
        .intr_pend_o    (intr_pend_o),
        .wake_o         (wake_o),
        .idle_to_read_o (idle_to_read_o)
    );

    assign entry_nmi_o = nmi_pend_o;
    assign entry_irq_o = irq_pend_o & ~nmi_pend_o;

    // R9
    entry_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({entry_nmi_o, entry_irq_o}));
    // R5
    combined_covers_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(nmi_pend_o) |-> intr_pend_o);
endmodule

// File: tb/intr_sample_unit_tb.sv
module intr_sample_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_req = 0, irq_req = 0, dis = 0, lock = 0, last = 0, idle = 0, ackn = 0, acki = 0;
    logic np, ip, cp, wake, itr, en, ei;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    intr_sample_unit #(.SYNC_STAGES(2)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .nmi_req_i(nmi_req), .irq_req_i(irq_req),
        .irq_disable_i(dis), .lock_i(lock), .last_cycle_i(last), .idle_slot_i(idle),
        .ack_nmi_i(ackn), .ack_irq_i(acki), .nmi_pend_o(np), .irq_pend_o(ip),
        .intr_pend_o(cp), .wake_o(wake), .idle_to_read_o(itr),
        .entry_nmi_o(en), .entry_irq_o(ei)
    );

    // inputs {nmi,irq,dis,lock,last,ackn,acki,idle} _ expected {np,ip,cp,wake,itr}
    localparam int NSTEP = 29;
    localparam logic [12:0] STEPS [NSTEP] = '{
        13'b00000001_00000, // 0 idle with nothing pending (R7)
        13'b10000000_00000, // 1 nmi rises
        13'b10000000_00000, // 2
        13'b10000000_00000, // 3 edge recorded (R10)
        13'b10001000_10110, // 4 sample consumes nmi (R2, R10)
        13'b10001001_10101, // 5 held level no retrigger, idle converted (R2, R7)
        13'b10000100_00000, // 6 ack nmi (R8)
        13'b10001000_00000, // 7 level still high, no event (R2)
        13'b00000000_00000, // 8
        13'b01100000_00000, // 9 irq level, masked
        13'b01100000_00000, // 10
        13'b01101000_00010, // 11 masked sample: wake only (R3, R6, R10)
        13'b01000000_00000, // 12 disable now clear, no sample (R3)
        13'b01001001_01111, // 13 next final cycle admits irq (R3, R7)
        13'b01011000_01100, // 14 locked (R4)
        13'b00000011_00000, // 15 ack irq, idle not converted (R8, R7)
        13'b00000000_00000, // 16
        13'b00000000_00000, // 17
        13'b00001000_00000, // 18 edge already consumed (R3)
        13'b10000000_00000, // 19
        13'b10000000_00000, // 20
        13'b10000000_00000, // 21
        13'b10011000_00000, // 22 lock keeps edge (R4)
        13'b10001000_10110, // 23 edge survived lock (R4)
        13'b01000000_10100, // 24 no sample, hold (R5)
        13'b01000000_10100, // 25
        13'b01001000_11110, // 26 both pending (R9)
        13'b00000100_01100, // 27 nmi ack, irq entry next (R9)
        13'b00000010_00000  // 28 all cleared (R8)
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input logic e_np, input logic e_ip, input logic e_cp, input logic e_wk);
        chk("R2", "nmi_pend", np, e_np);
        chk("R3", "irq_pend", ip, e_ip);
        chk("R5", "intr_pend", cp, e_cp);
        chk("R6", "wake", wake, e_wk);
        chk("R9", "entry_nmi", en, e_np);
        chk("R9", "entry_irq", ei, e_ip & ~e_np);
    endtask

    task automatic drive(input logic [7:0] v);
        {nmi_req, irq_req, dis, lock, last, ackn, acki, idle} = v;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset nmi_pend", np, 1'b0);
        chk("R1", "reset intr_pend", cp, 1'b0);
        chk("R1", "reset wake", wake, 1'b0);
        chk("R1", "reset idle_to_read", itr, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "post-reset intr_pend", cp, 1'b0);

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            drive(STEPS[i][12:5]);
            #5;
            chk("R7", $sformatf("idle_to_read step %0d", i), itr, STEPS[i][0]);
            @(posedge clk); #1;
            chk_regs(STEPS[i][4], STEPS[i][3], STEPS[i][2], STEPS[i][1]);
        end
        @(negedge clk) drive(8'b0);

        // R10: nmi sample one edge too early misses, next one hits
        repeat (3) @(negedge clk);
        nmi_req = 1'b1;
        @(negedge clk);
        @(negedge clk) last = 1'b1;   // edge k+2: edge being recorded now
        @(posedge clk); #1;
        chk("R10", "nmi not yet sampleable", np, 1'b0);
        @(posedge clk); #1;           // edge k+3
        chk("R10", "nmi sampled at k+3", np, 1'b1);
        @(negedge clk) last = 1'b0;

        // R1: reset mid-run clears pending state
        @(negedge clk) rst_n = 1'b0;
        #2;
        chk("R1", "async reset nmi_pend", np, 1'b0);
        chk("R1", "async reset intr_pend", cp, 1'b0);
        @(negedge clk) begin rst_n = 1'b1; nmi_req = 1'b0; end
        @(negedge clk) last = 1'b1;
        @(posedge clk); #1;
        chk("R1", "no stale event after reset", np, 1'b0);
        @(negedge clk) last = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule